// File: doc/BRIEF.md
# Mode-Controlled GPIO Port

An eight-pin general-purpose I/O port. It holds a data latch and a control register with a two-bit mode field for each pin. The mode field hands the pin to an alternate peripheral, makes it a push output driven from the latch, or makes it an input with or without its pull-up. A small synchronous register bus writes the latch and the two bytes of the mode register, and reads them back.

A read of the data address is built per pin. Pins in peripheral or output mode return their latch bit. Pins in either input mode return the pin level after a two-flop synchroniser. A write to the latch always updates the stored bit, but only pins in output mode show it at the pad.

Top module: `gpio_mode_port`

## Requirements
- R1: After reset the latch and every mode field are 0, so every pin is in peripheral mode with `alt_sel` all ones, `pad_pu` all zeros and the data address reading 0x00.
- R2: The mode field of pin n sits at bits [2n+1:2n] of the 16-bit mode register. Code 00 is peripheral, 01 is output, 10 is input with pull-up, 11 is input without pull-up. `alt_sel[n]` is high only for code 00.
- R3: A write to address 0 updates all eight latch bits whatever the pins' modes. The written value is visible at the pads once the pins are switched to output mode.
- R4: In mode 01, `pad_out[n]` equals latch bit n and `pad_oe[n]` is 1.
- R5: In modes 10 and 11, `pad_oe[n]` and `pad_out[n]` are 0, whatever the latch holds.
- R6: A read of address 0 returns latch bit n for pins in mode 00 or 01, and the synchronised pin level for pins in mode 10 or 11.
- R7: `pad_pu[n]` is 1 only in mode 10.
- R8: Pin inputs pass through two synchroniser flops, and the read data register adds one more. A pin change is first seen on `bus_rdata` on the third rising edge after it.
- R9: In mode 00, `pad_out[n]` and `pad_oe[n]` follow `alt_out[n]` and `alt_oe[n]`.
- R10: Address 1 holds the mode fields of pins 0 to 3 and address 2 those of pins 4 to 7. A byte write changes only the addressed half. Address 3 reads as 0x00 and writes to it change nothing.
- R11: `bus_rdata` is registered. It takes the value selected by `bus_addr` at the rising edge, and holds between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 latch, 1 mode low, 2 mode high |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Raw pad input levels |
| alt_out | input | 8 | Peripheral output values |
| alt_oe | input | 8 | Peripheral output enables |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |
| alt_sel | output | 8 | High where a pin is handed to the peripheral |

## Verification
The bench writes the latch while every pin is an input and then checks that the pads stay undriven. A design that lets the mode gate the latch write, or that leaks the latch to the pad, fails this check. A mixed-mode read checks the per-pin read mux: one that switches on the wrong mode bit returns pin levels for output pins. A pin edge is timed against the third clock edge, so a missing or extra synchroniser stage shows up. Byte writes to each mode half, and writes to the unused address, catch decoders that clobber the other half.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int MODE_W = 2;
   typedef enum logic [MODE_W-1:0] {
      PM_PERIPH = 2'b00,
      PM_OUTPUT = 2'b01,
      PM_IN_PU  = 2'b10,
      PM_IN_NPU = 2'b11
   } pin_mode_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];

   // R8
   sync_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> q_sync == $past(stage_q[STAGES-2]));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
   parameter int PINS   = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [PINS-1:0]   bus_wdata,
   input  logic              bus_wr,
   input  logic [PINS-1:0]   pin_sync,
   output logic [PINS-1:0]   latch_q,
   output logic [2*PINS-1:0] mode_q,
   output logic [PINS-1:0]   bus_rdata
);
   localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_MLOW  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_MHIGH = ADDR_W'(2);

   logic [PINS-1:0] rd_next;
   logic [PINS-1:0] port_view;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
         mode_q  <= '0;
      end else if (bus_wr) begin
         unique case (bus_addr)
            A_LATCH: latch_q             <= bus_wdata;
            A_MLOW:  mode_q[PINS-1:0]    <= bus_wdata;
            A_MHIGH: mode_q[2*PINS-1:PINS] <= bus_wdata;
            default: ;
         endcase
      end
   end

   generate
      for (genvar n = 0; n < PINS; n++) begin : g_view
         assign port_view[n] = mode_q[2*n+1] ? pin_sync[n] : latch_q[n];
      end
   endgenerate

   always_comb begin
      unique case (bus_addr)
         A_LATCH: rd_next = port_view;
         A_MLOW:  rd_next = mode_q[PINS-1:0];
         A_MHIGH: rd_next = mode_q[2*PINS-1:PINS];
         default: rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_next;
   end

   // R3
   latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_LATCH |=> latch_q == $past(bus_wdata));
   // R10
   mlow_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_MLOW |=> $stable(mode_q[2*PINS-1:PINS]));
   // R10
   mhigh_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_MHIGH |=> $stable(mode_q[PINS-1:0]));
   // R10
   unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(3) |=> $stable(mode_q) && $stable(latch_q));
endmodule

// File: rtl/gpio_port_pin.sv
module gpio_port_pin
   import gpio_port_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   input  logic              latch_bit,
   input  logic              alt_o,
   input  logic              alt_e,
   output logic              pad_o,
   output logic              pad_e,
   output logic              pull_en,
   output logic              periph_sel
);
   pin_mode_e m;
   assign m = pin_mode_e'(mode);

   always_comb begin
      pad_o      = 1'b0;
      pad_e      = 1'b0;
      pull_en    = 1'b0;
      periph_sel = 1'b0;
      unique case (m)
         PM_PERIPH: begin
            pad_o      = alt_o;
            pad_e      = alt_e;
            periph_sel = 1'b1;
         end
         PM_OUTPUT: begin
            pad_o = latch_bit;
            pad_e = 1'b1;
         end
         PM_IN_PU:  pull_en = 1'b1;
         PM_IN_NPU: ;
         default: ;
      endcase
   end

   // R7
   pull_only_in_pu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pull_en |-> mode == 2'b10);
   // R5
   input_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode[1] |-> !pad_e && !pad_o);
   // R4
   output_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'b01 |-> pad_e && pad_o == latch_bit);
   // R2
   periph_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      periph_sel |-> mode == 2'b00 && pad_e == alt_e);
endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
   import gpio_port_pkg::*;
#(
   parameter int PINS        = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [PINS-1:0]   bus_wdata,
   input  logic              bus_wr,
   output logic [PINS-1:0]   bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   input  logic [PINS-1:0]   alt_out,
   input  logic [PINS-1:0]   alt_oe,
   output logic [PINS-1:0]   pad_out,
   output logic [PINS-1:0]   pad_oe,
   output logic [PINS-1:0]   pad_pu,
   output logic [PINS-1:0]   alt_sel
);
   localparam int MODE_BITS = MODE_W * PINS;

   generate
      if (PINS < 1) begin : g_bad_pins
         $error("PINS must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must cover three registers");
      end
   endgenerate

   logic [PINS-1:0]      pin_sync;
   logic [PINS-1:0]      latch_q;
   logic [MODE_BITS-1:0] mode_q;

   gpio_port_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_sync));

   gpio_port_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .pin_sync(pin_sync), .latch_q(latch_q),
      .mode_q(mode_q), .bus_rdata(bus_rdata));

   generate
      for (genvar n = 0; n < PINS; n++) begin : g_pin
         gpio_port_pin u_pin (
            .clk(clk), .rst_n(rst_n),
            .mode(mode_q[MODE_W*n +: MODE_W]), .latch_bit(latch_q[n]),
            .alt_o(alt_out[n]), .alt_e(alt_oe[n]),
            .pad_o(pad_out[n]), .pad_e(pad_oe[n]),
            .pull_en(pad_pu[n]), .periph_sel(alt_sel[n]));
      end
   endgenerate

   // R9
   periph_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & alt_sel) == (alt_oe & alt_sel) && (pad_out & alt_sel) == (alt_out & alt_sel));
   // R2
   pull_excludes_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & alt_sel) == '0);
endmodule

// File: tb/tb_gpio_mode_port.sv
module tb_gpio_mode_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = '0;
   logic [7:0] alt_out = '0;
   logic [7:0] alt_oe = '0;
   logic [7:0] pad_out, pad_oe, pad_pu, alt_sel;
   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   gpio_mode_port dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe),
      .pad_pu(pad_pu), .alt_sel(alt_sel));

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      @(posedge clk);
      #1 d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      #1;
      check("R1 alt_sel", alt_sel, 8'hFF);
      check("R1 pad_pu", pad_pu, 8'h00);
      rd(2'd0, v); check("R1 latch read", v, 8'h00);
      rd(2'd1, v); check("R1 mode low", v, 8'h00);
      rd(2'd2, v); check("R1 mode high", v, 8'h00);
   endtask

   task automatic t_periph();
      alt_out = 8'h5A; alt_oe = 8'h33;
      #1;
      check("R9 pad_out", pad_out, 8'h5A);
      check("R9 pad_oe", pad_oe, 8'h33);
      check("R2 alt_sel periph", alt_sel, 8'hFF);
   endtask

   task automatic t_latch_any_mode();
      logic [7:0] v;
      pin_in = 8'h00;
      wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
      wr(2'd0, 8'h99);
      settle();
      check("R5 pad_oe input", pad_oe, 8'h00);
      check("R5 pad_out input", pad_out, 8'h00);
      check("R2 alt_sel input", alt_sel, 8'h00);
      check("R7 pad_pu mode11", pad_pu, 8'h00);
      rd(2'd0, v); check("R6 read pin not latch", v, 8'h00);
      wr(2'd1, 8'h55); wr(2'd2, 8'h55);
      #1;
      check("R3 latch kept", pad_out, 8'h99);
      check("R4 pad_oe output", pad_oe, 8'hFF);
      rd(2'd0, v); check("R6 read latch", v, 8'h99);
   endtask

   task automatic t_inputs();
      logic [7:0] v;
      wr(2'd1, 8'hAA); wr(2'd2, 8'hFF);
      wr(2'd0, 8'hFF);
      pin_in = 8'h0F;
      settle();
      check("R7 pad_pu mixed", pad_pu, 8'h0F);
      check("R5 pad_oe", pad_oe, 8'h00);
      rd(2'd0, v); check("R6 input read", v, 8'h0F);
   endtask

   task automatic t_mixed_read();
      logic [7:0] v;
      wr(2'd1, 8'h55); wr(2'd2, 8'hAA);
      wr(2'd0, 8'h06);
      pin_in = 8'hC3;
      settle();
      rd(2'd0, v); check("R6 mixed read", v, 8'hC6);
      check("R4 mixed pad_out", pad_out, 8'h06);
      check("R4 mixed pad_oe", pad_oe, 8'h0F);
      check("R7 mixed pad_pu", pad_pu, 8'hF0);
   endtask

   task automatic t_byte_write();
      logic [7:0] v;
      wr(2'd1, 8'h00); wr(2'd2, 8'h00);
      wr(2'd1, 8'h1B);
      rd(2'd2, v); check("R10 high untouched", v, 8'h00);
      rd(2'd1, v); check("R10 low written", v, 8'h1B);
      wr(2'd2, 8'hE4);
      rd(2'd1, v); check("R10 low kept", v, 8'h1B);
      rd(2'd2, v); check("R10 high written", v, 8'hE4);
      wr(2'd3, 8'hFF);
      rd(2'd3, v); check("R10 addr3 reads zero", v, 8'h00);
      rd(2'd1, v); check("R10 addr3 no effect low", v, 8'h1B);
      rd(2'd2, v); check("R10 addr3 no effect high", v, 8'hE4);
   endtask

   task automatic t_latency();
      wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
      pin_in = 8'h00;
      settle();
      bus_addr = 2'd0;
      @(negedge clk);
      pin_in = 8'hA5;
      @(posedge clk); @(posedge clk);
      #1 check("R8 not yet at edge two", bus_rdata, 8'h00);
      @(posedge clk);
      #1 check("R8 seen at edge three", bus_rdata, 8'hA5);
   endtask

   task automatic t_read_reg();
      wr(2'd1, 8'h55); wr(2'd2, 8'h55);
      wr(2'd0, 8'h3C);
      settle();
      bus_addr = 2'd0;
      @(negedge clk);
      check("R11 latch before switch", bus_rdata, 8'h3C);
      bus_addr = 2'd1;
      #2 check("R11 holds between edges", bus_rdata, 8'h3C);
      @(posedge clk);
      #1 check("R11 updates at edge", bus_rdata, 8'h55);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_periph();
      t_latch_any_mode();
      t_inputs();
      t_mixed_read();
      t_byte_write();
      t_latency();
      t_read_reg();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #2000000;
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule